// File: doc/BRIEF.md
# Time-Multiplexed Two-Slot Memory Port

This block holds one single-port synchronous RAM. It runs that RAM at twice the processor clock, so that a small stack-machine processor gets two memory accesses in each of its cycles. Every processor cycle holds two fast cycles. The first fast cycle is the fetch slot, which reads the instruction address. The second is the data slot, which reads the data address and can also write it. Each result goes into its own holding register. The processor then sees a steady instruction word and a steady data word.

The fast clock and the processor clock come from the same source and are in phase. Reset is synchronous to the fast clock and must be released on a fast edge that lines up with a processor edge. This makes the slot bit start in the fetch slot. The processor keeps all of its request inputs steady for the whole processor cycle.

The data address comes straight from the top of the processor's data stack, so it is valid when the cycle starts. The data word may arrive half a processor cycle after the instruction word, because it only feeds the processor's result multiplexer.

Top module: `twin_slot_ram`

## Requirements
- R1: An internal slot bit alternates on every fast clock edge. The first fast cycle after reset release is the fetch slot (RAM address = `i_addr`). The next fast cycle is the data slot (RAM address = `d_addr`). Before the second fast edge after a processor-cycle start, `i_word` keeps the value it had before that cycle.
- R2: The word stored at the `i_addr` presented in a processor cycle appears on `i_word` after the second fast edge of that cycle, which is the next processor edge.
- R3: `i_word` changes only at the edge that ends a data slot. `d_rdata` changes only at the edge that ends a fetch slot. Each output therefore holds for a full processor period.
- R4: The word stored at the `d_addr` presented in a processor cycle appears on `d_rdata` after the first fast edge of the following processor cycle.
- R5: When `d_we` is 1, `d_wdata` is written to `d_addr` in the data slot. Fetches and data reads in all later processor cycles return the new word.
- R6: A data read whose address is written in the same processor cycle returns the old contents (read-before-write).
- R7: A fetch from the address that the same processor cycle writes returns the old contents, because the fetch slot comes first.
- R8: While `rst` is 1, both `i_word` and `d_rdata` are 0 after the next fast edge, and nothing is written to the RAM even if `d_we` is 1.
- R9: When `d_we` is 0, the RAM contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Fast clock, twice the processor clock, in phase with it |
| rst | input | 1 | Synchronous reset, active high |
| i_addr | input | AW | Instruction fetch address |
| i_word | output | DW | Held instruction word |
| d_addr | input | AW | Data access address |
| d_wdata | input | DW | Data write word |
| d_we | input | 1 | Data write enable, active high |
| d_rdata | output | DW | Held data read word |

## Verification
Call the two fast edges of a processor cycle A and B. The instruction word is due after edge B of the cycle that presented its address. The data word is due after edge A of the following cycle. The bench drives a request on the falling edge before A. After A, it checks the previous cycle's data word and confirms that the instruction word has not yet moved. After B, it checks the new instruction word and confirms that the data word has held. A behavioural memory model gives every expected value: both reads of a cycle take the model's contents before that cycle's write is applied.

// File: rtl/twin_slot_ram.sv
module twin_slot_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_2x,
  input  logic          rst,
  input  logic [AW-1:0] i_addr,
  output logic [DW-1:0] i_word,
  input  logic [AW-1:0] d_addr,
  input  logic [DW-1:0] d_wdata,
  input  logic          d_we,
  output logic [DW-1:0] d_rdata
);
  localparam int DEPTH = 1 << AW;

  logic          slot;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ram_q;
  logic [AW-1:0] ram_addr;
  logic          ram_we;

  assign ram_addr = slot ? d_addr : i_addr;
  assign ram_we   = slot & d_we & ~rst;

  always_ff @(posedge clk_2x)
    if (rst) slot <= 1'b0;
    else     slot <= ~slot;

  always_ff @(posedge clk_2x) begin
    if (ram_we) mem[ram_addr] <= d_wdata;
    ram_q <= mem[ram_addr];
  end

  always_ff @(posedge clk_2x)
    if (rst) begin
      i_word  <= '0;
      d_rdata <= '0;
    end else if (slot) begin
      i_word  <= ram_q;
    end else begin
      d_rdata <= ram_q;
    end

  AST_SLOT_ALTERNATES: assert property (@(posedge clk_2x) disable iff (rst) 1'b1 |=> slot != $past(slot)); // R1
  AST_FETCH_HOLD: assert property (@(posedge clk_2x) disable iff (rst) !slot |=> $stable(i_word)); // R3
  AST_DATA_HOLD: assert property (@(posedge clk_2x) disable iff (rst) slot |=> $stable(d_rdata)); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk_2x) rst |=> (i_word == '0 && d_rdata == '0)); // R8
endmodule

// File: tb/test_twin_slot_ram.sv
module test_twin_slot_ram;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk_2x = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] i_addr = '0;
  logic [AW-1:0] d_addr = '0;
  logic [DW-1:0] d_wdata = '0;
  logic          d_we = 1'b0;
  logic [DW-1:0] i_word;
  logic [DW-1:0] d_rdata;

  twin_slot_ram #(.AW(AW), .DW(DW)) i_twin_slot_ram (
    .clk_2x(clk_2x), .rst(rst), .i_addr(i_addr), .i_word(i_word),
    .d_addr(d_addr), .d_wdata(d_wdata), .d_we(d_we), .d_rdata(d_rdata));

  always #2.5 clk_2x = ~clk_2x;

  logic [DW-1:0] model [DEPTH];
  int checks = 0;
  int fails = 0;
  bit have_prev = 0;
  bit chk_on = 0;
  logic [DW-1:0] prev_d, last_i;

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
    return model[a];
  endfunction

  task automatic step(input logic [AW-1:0] ia, input logic [AW-1:0] da,
                      input logic [DW-1:0] wd, input logic we);
    logic [DW-1:0] exp_i, exp_d;
    exp_i = model_rd(ia);
    exp_d = model_rd(da);
    i_addr = ia; d_addr = da; d_wdata = wd; d_we = we;
    @(posedge clk_2x); @(negedge clk_2x);
    if (chk_on && have_prev) begin
      chk("R4 data word after next cycle's first edge", d_rdata, prev_d);
      chk("R1 fetch result not before second edge", i_word, last_i);
    end
    @(posedge clk_2x); @(negedge clk_2x);
    if (chk_on) begin
      chk("R2 instruction word at processor edge", i_word, exp_i);
      if (have_prev) chk("R3 data word held", d_rdata, prev_d);
    end
    if (we) model[da] = wd;
    last_i = exp_i; prev_d = exp_d; have_prev = 1;
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    d_we = 1'b1; d_addr = 8'd5; d_wdata = 16'hDEAD;
    repeat (4) @(negedge clk_2x);
    chk("R8 i_word zero in reset", i_word, '0);
    chk("R8 d_rdata zero in reset", d_rdata, '0);
    rst = 1'b0;
    for (int a = 0; a < DEPTH; a++) step(8'(a), 8'(a), 16'(a * 16'h0101 + 16'h37), 1'b1);
    chk_on = 1; have_prev = 0;
    step(8'd10, 8'd10, 16'h1111, 1'b0);
    // R6: read and write of the same address in one cycle
    step(8'd3, 8'd10, 16'hAAAA, 1'b1);
    step(8'd10, 8'd10, 16'h0, 1'b0);
    chk("R5 written word fetched", i_word, 16'hAAAA);
    // R7: fetch and write of the same address in one cycle
    step(8'd20, 8'd20, 16'hBBBB, 1'b1);
    step(8'd20, 8'd21, 16'h0, 1'b0);
    chk("R7 later fetch sees write", i_word, 16'hBBBB);
    // R9: no write with enable low
    step(8'd30, 8'd30, 16'h1234, 1'b0);
    step(8'd30, 8'd30, 16'h0, 1'b0);
    chk("R9 contents unchanged", i_word, model[30]);
    // R8: reset blocks writes
    rst = 1'b1; d_we = 1'b1; d_addr = 8'd40; d_wdata = 16'hCCCC;
    repeat (4) @(negedge clk_2x);
    chk("R8 i_word zero in reset", i_word, '0);
    chk("R8 d_rdata zero in reset", d_rdata, '0);
    rst = 1'b0; have_prev = 0;
    step(8'd40, 8'd40, 16'h0, 1'b0);
    step(8'd41, 8'd40, 16'h0, 1'b0);
    chk("R8 no write during reset", i_word, model[41]);
    step(8'd40, 8'd40, 16'h0, 1'b0);
    chk("R8 address kept old word", i_word, 16'((40) * 16'h0101 + 16'h37));
    for (int n = 0; n < 2000; n++) begin
      logic [AW-1:0] ia, da;
      ia = 8'($urandom);
      da = ($urandom % 4 == 0) ? ia : 8'($urandom);
      step(ia, da, 16'($urandom), 1'($urandom));
    end
    step(8'd0, 8'd0, 16'h0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule